// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs a single external bus cycle on behalf of an internal requester. A request carries an address, a write flag, two byte enables and write data. The block then drives a 20-bit address, a 16-bit data path, four active-low chip selects, and the read, combined-write, low-byte-write, high-byte-enable and address-latch strobes. It returns a one-clock acknowledge, and on reads it also returns the data sampled from the bus. The two top address bits pick the chip-select region.

Every region has a 2-bit software wait code and a wait-disable flag. With waits enabled, the code adds code+1 bus-clock periods, and the active-low ready input is honoured once those periods have elapsed. Ready is sampled on the falling bus-clock edge of the final period. Each low sample adds one full period, and every bus output is held while it lasts. With waits disabled, the cycle has no software waits and ready is ignored. The block runs on a clock at twice the bus-clock rate and produces the bus clock itself. A mode input chooses between separate and multiplexed address/data operation. In multiplexed operation, an address-latch period comes first.

Top module: `ext_bus_waitctl`

## Requirements
- R1: After synchronous reset: all chip selects and strobes high, address latch low, hold-acknowledge high, acknowledge low, data output disabled.
- R2: During a cycle exactly one chip select is low: index req_addr[19:18]. At all other times none is low.
- R3: With waits enabled, a region adds code+1 bus-clock periods of software wait. With waits disabled it adds none. In separate mode, chip select stays low for 2*(1+waits+ready waits) clocks.
- R4: Ready is sampled only at the falling bus-clock edge of the final period. Each low sample adds exactly one bus-clock period (two clocks), and ready is sampled again at each following falling edge.
- R5: For a region whose wait-disable bit is 1, ready is ignored, even when held low for the whole cycle.
- R6: A low ready during the software-wait periods has no effect on cycle length.
- R7: While a ready-inserted wait lasts, the address, data output, data enable, chip selects, all strobes, address latch and hold-acknowledge do not change.
- R8: In multiplexed mode, the cycle starts with one extra bus-clock period. In it the address latch is high, the data lines carry req_addr[15:0] with output enabled, and the read/write strobes stay high.
- R9: In the data periods of a write, wr_n is low, wrl_n equals ~be[0] and wrh_n equals ~be[1], and the data lines carry the write data with output enabled. In a read, rd_n is low and output is disabled. bhe_n equals ~be[1] for the whole cycle.
- R10: The acknowledge is high for exactly one clock, at the clock after the cycle ends. Read data is the data input captured at the final accepted falling edge.
- R11: The bus clock toggles on every clock. A cycle begins on a rising bus-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| mux_mode | input | 1 | 1 = multiplexed address/data, 0 = separate |
| sw_wait | input | 8 | Wait code per region, region i at bits [2i+1:2i] |
| wait_dis | input | 4 | Per-region wait-disable flag (1 = no waits, ready ignored) |
| req | input | 1 | Request, held until acknowledge |
| req_addr | input | 20 | Request address |
| req_we | input | 1 | 1 = write |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| bclk | output | 1 | Bus clock |
| bus_addr | output | 20 | Address bus |
| bus_dout | output | 16 | Data/address lines, driven value |
| bus_doe | output | 1 | Data line output enable |
| bus_din | input | 16 | Data lines, sampled value |
| cs_n | output | 4 | Chip selects, active low |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Combined write strobe |
| wrl_n | output | 1 | Low-byte write strobe |
| wrh_n | output | 1 | High-byte write strobe |
| bhe_n | output | 1 | High-byte enable |
| ale | output | 1 | Address latch enable |
| hlda_n | output | 1 | Hold acknowledge, held inactive |
| rdy_n | input | 1 | Ready, active low |

## Verification
The hard corner is the software-wait count and the ready stretch touching at the same falling edge. The last software period and the first ready sample share one edge, and a low ready one period too early must not count. The bench holds ready low through every software-wait period and then for exactly n sample points, with n of 0, 1 and 5, in both bus modes. Its per-clock model gives the clock at which chip select must rise, and a mismatch in the count or a moved output is reported at that clock.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACT  = 2'd2
  } ebw_state_t;
endpackage

// File: rtl/ebw_phase.sv
module ebw_phase (
  input  logic clk,
  input  logic rst,
  output logic ph,
  output logic bclk
);
  logic ph_q;

  // ph_q = 1 : second (low) half of a bus-clock period
  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b1;
    else     ph_q <= ~ph_q;
  end

  assign ph   = ph_q;
  assign bclk = ~ph_q;

  a_r11_bclk_toggle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bclk != $past(bclk)));
endmodule

// File: rtl/ebw_cfgsel.sv
module ebw_cfgsel #(
  parameter int NCS = 4,
  parameter int WCW = 2,
  localparam int CW = $clog2(NCS),
  localparam int PW = WCW + 1
) (
  input  logic [NCS*WCW-1:0] sw_wait,
  input  logic [NCS-1:0]     wait_dis,
  input  logic [CW-1:0]      region,
  output logic [PW-1:0]      sw_per,
  output logic               honor
);
  logic [WCW-1:0] code [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_code
    assign code[g] = sw_wait[g*WCW +: WCW];
  end

  always_comb begin
    honor  = ~wait_dis[region];
    sw_per = honor ? (PW'(code[region]) + PW'(1)) : '0;
  end
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
  import ebw_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int PW  = 3,
  localparam int CW = $clog2(NCS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph,
  input  logic          mux_mode,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [PW-1:0] sw_per,
  input  logic          honor,
  input  logic          rdy_n,
  input  logic [DW-1:0] bus_din,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [NCS-1:0] cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          wrl_n,
  output logic          wrh_n,
  output logic          bhe_n,
  output logic          ale,
  output logic          hlda_n
);
  ebw_state_t    st;
  logic [PW-1:0] pcnt;
  logic          fin, rwait, honor_q, we_q;
  logic [1:0]    be_q;
  logic [DW-1:0] wd_q;
  logic [CW-1:0] region;

  assign region = req_addr[AW-1 -: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  pcnt <= '0;  fin <= 1'b0;  rwait <= 1'b0;
      honor_q <= 1'b0;  we_q <= 1'b0;  be_q <= '0;  wd_q <= '0;
      ack <= 1'b0;  rdata <= '0;  bus_addr <= '0;  bus_dout <= '0;
      bus_doe <= 1'b0;  cs_n <= '1;  rd_n <= 1'b1;  wr_n <= 1'b1;
      wrl_n <= 1'b1;  wrh_n <= 1'b1;  bhe_n <= 1'b1;  ale <= 1'b0;
      hlda_n <= 1'b1;
    end else begin
      ack <= 1'b0;
      unique case (st)
        ST_IDLE: if (req && ph) begin
          bus_addr <= req_addr;  we_q <= req_we;  be_q <= req_be;
          wd_q <= req_wdata;  honor_q <= honor;  pcnt <= sw_per;
          fin <= 1'b0;  rwait <= 1'b0;
          cs_n  <= ~(NCS'(1) << region);
          bhe_n <= ~req_be[1];
          if (mux_mode) begin
            st <= ST_ADDR;  ale <= 1'b1;
            bus_dout <= req_addr[DW-1:0];  bus_doe <= 1'b1;
          end else begin
            st <= ST_ACT;
            rd_n  <= req_we;  wr_n <= ~req_we;
            wrl_n <= ~(req_we & req_be[0]);  wrh_n <= ~(req_we & req_be[1]);
            bus_dout <= req_wdata;  bus_doe <= req_we;
          end
        end
        ST_ADDR: if (ph) begin
          st <= ST_ACT;  ale <= 1'b0;
          rd_n  <= we_q;  wr_n <= ~we_q;
          wrl_n <= ~(we_q & be_q[0]);  wrh_n <= ~(we_q & be_q[1]);
          bus_dout <= wd_q;  bus_doe <= we_q;
        end
        ST_ACT: begin
          if (!ph) begin
            // falling bus-clock edge
            if (pcnt == '0) begin
              if (honor_q && !rdy_n) rwait <= 1'b1;
              else begin
                rwait <= 1'b0;  fin <= 1'b1;
                if (!we_q) rdata <= bus_din;
              end
            end
          end else if (fin) begin
            st <= ST_IDLE;  fin <= 1'b0;  ack <= 1'b1;
            cs_n <= '1;  rd_n <= 1'b1;  wr_n <= 1'b1;  wrl_n <= 1'b1;
            wrh_n <= 1'b1;  bhe_n <= 1'b1;  bus_doe <= 1'b0;
          end else if (pcnt != '0) begin
            pcnt <= pcnt - PW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  a_r2_idle_no_cs: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (cs_n == '1));
  a_r5_no_ready_wait: assert property (@(posedge clk) disable iff (rst)
    !honor_q |-> !rwait);
  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    (rwait && $past(rwait)) |-> ($stable(bus_addr) && $stable(bus_dout) &&
      $stable(bus_doe) && $stable(cs_n) && $stable(rd_n) && $stable(wr_n) &&
      $stable(wrl_n) && $stable(wrh_n) && $stable(bhe_n) && $stable(ale) &&
      $stable(hlda_n)));
  a_r8_ale_quiet: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && wrl_n && wrh_n));
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl #(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int WCW = 2,
  localparam int CW = $clog2(NCS),
  localparam int PW = WCW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mux_mode,
  input  logic [NCS*WCW-1:0] sw_wait,
  input  logic [NCS-1:0]     wait_dis,
  input  logic               req,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_we,
  input  logic [1:0]         req_be,
  input  logic [DW-1:0]      req_wdata,
  output logic               ack,
  output logic [DW-1:0]      rdata,
  output logic               bclk,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_dout,
  output logic               bus_doe,
  input  logic [DW-1:0]      bus_din,
  output logic [NCS-1:0]     cs_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic               wrl_n,
  output logic               wrh_n,
  output logic               bhe_n,
  output logic               ale,
  output logic               hlda_n,
  input  logic               rdy_n
);
  logic          ph, honor;
  logic [PW-1:0] sw_per;

  ebw_phase u_phase (.clk(clk), .rst(rst), .ph(ph), .bclk(bclk));

  ebw_cfgsel #(.NCS(NCS), .WCW(WCW)) u_cfg (
    .sw_wait(sw_wait), .wait_dis(wait_dis), .region(req_addr[AW-1 -: CW]),
    .sw_per(sw_per), .honor(honor));

  ebw_seq #(.AW(AW), .DW(DW), .NCS(NCS), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .ph(ph), .mux_mode(mux_mode), .req(req),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .sw_per(sw_per), .honor(honor), .rdy_n(rdy_n),
    .bus_din(bus_din), .ack(ack), .rdata(rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .bhe_n(bhe_n), .ale(ale),
    .hlda_n(hlda_n));
endmodule

// File: tb/ext_bus_waitctl_tb.sv
module ext_bus_waitctl_tb;
  localparam logic [7:0] SWW  = 8'hE4;   // CS0:00 CS1:01 CS2:10 CS3:11
  localparam logic [3:0] WDIS = 4'b0100; // CS2 waits disabled

  logic clk = 1'b0, rst = 1'b1;
  logic mux_mode = 1'b0, req = 1'b0, req_we = 1'b0, rdy_n = 1'b1;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic ack, bclk, bus_doe, rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale, hlda_n;
  logic [15:0] rdata, bus_dout;
  logic [19:0] bus_addr;
  logic [3:0]  cs_n;
  int total = 0, bad = 0, wd = 0;
  logic [15:0] exp_rdata = '0;

  always #2.5 clk = ~clk;

  ext_bus_waitctl u_dut (
    .clk(clk), .rst(rst), .mux_mode(mux_mode), .sw_wait(SWW), .wait_dis(WDIS),
    .req(req), .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .bclk(bclk),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n),
    .wrh_n(wrh_n), .bhe_n(bhe_n), .ale(ale), .hlda_n(hlda_n), .rdy_n(rdy_n));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {cs_n, rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale, hlda_n, bus_doe}
  function automatic logic [11:0] pins();
    return {cs_n, rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale, hlda_n, bus_doe};
  endfunction

  task automatic run(input bit mux, input logic [19:0] addr, input bit we,
                     input logic [1:0] be, input logic [15:0] wdat,
                     input logic [15:0] din, input int n, input bit force_low,
                     input string tag);
    int idx, code, sw, rw, len, sp, guard;
    bit dis;
    logic [11:0] e;
    logic [15:0] edo;
    idx  = int'(addr[19:18]);
    code = int'((SWW >> (2*idx)) & 8'h3);
    dis  = WDIS[idx];
    sw   = dis ? 0 : code + 1;
    rw   = dis ? 0 : n;
    len  = 2 * ((mux ? 1 : 0) + 1 + sw + rw);
    sp   = 2 * ((mux ? 1 : 0) + sw) + 1;
    @(negedge clk);
    mux_mode = mux; req_addr = addr; req_we = we; req_be = be;
    req_wdata = wdat; bus_din = din;
    rdy_n = force_low ? 1'b0 : !(1 < sp + 2*n);
    req = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (cs_n == 4'hF && guard < 10);
    chk(guard < 10, {tag, " R11 start"}, 64'(guard), 64'd0);
    for (int j = 0; j <= len + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (j < len) begin
        bit apar, act;
        apar = mux && (j < 2);
        act  = !apar;
        e[11:8] = ~(4'b1 << idx);
        e[7] = act ? we : 1'b1;
        e[6] = act ? ~we : 1'b1;
        e[5] = act ? ~(we & be[0]) : 1'b1;
        e[4] = act ? ~(we & be[1]) : 1'b1;
        e[3] = ~be[1];
        e[2] = apar;
        e[1] = 1'b1;
        e[0] = apar ? 1'b1 : we;
        edo  = apar ? addr[15:0] : wdat;
        if (j >= sp && j < sp + 2*rw)
          chk(pins() == e && bus_addr == addr && (!e[0] || bus_dout == edo),
              {tag, " R7 frozen in ready wait"}, {pins(), bus_dout, bus_addr},
              {e, edo, addr});
        else if (apar)
          chk(pins() == e && bus_addr == addr && bus_dout == edo,
              {tag, " R8 address phase"}, {pins(), bus_dout, bus_addr},
              {e, edo, addr});
        else
          chk(pins() == e && bus_addr == addr && (!e[0] || bus_dout == edo),
              {tag, " R9 R2 R3 data phase"}, {pins(), bus_dout, bus_addr},
              {e, edo, addr});
        chk(ack == 1'b0, {tag, " R10 no early ack"}, 64'(ack), 64'd0);
      end else if (j == len) begin
        if (!we) exp_rdata = din;
        chk(cs_n == 4'hF, {tag, " R3 R4 cycle length"}, 64'(cs_n), 64'hF);
        chk(pins() == 12'hFFA, {tag, " R1 idle pins"}, 64'(pins()), 64'hFFA);
        chk(ack == 1'b1, {tag, " R10 ack"}, 64'(ack), 64'd1);
        chk(rdata == exp_rdata, {tag, " R10 rdata"}, 64'(rdata), 64'(exp_rdata));
        req = 1'b0;
      end else begin
        chk(ack == 1'b0, {tag, " R10 ack one clock"}, 64'(ack), 64'd0);
      end
      rdy_n = force_low ? 1'b0 : !((j + 1) < sp + 2*n);
    end
    rdy_n = 1'b1;
  endtask

  initial begin
    logic b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pins() == 12'hFFA && ack == 1'b0, "R1 reset state",
        64'({pins(), ack}), 64'({12'hFFA, 1'b0}));
    b0 = bclk;
    @(negedge clk);
    chk(bclk != b0, "R11 bclk toggles", 64'(bclk), 64'(~b0));
    // separate mode, CS0 (code 00 -> one wait), ready waits 0/1/5
    run(1'b0, 20'h01234, 1'b0, 2'b11, 16'h0000, 16'hA5A5, 0, 1'b0, "R3 R6 cs0 n0");
    run(1'b0, 20'h01236, 1'b0, 2'b11, 16'h0000, 16'h5A5A, 1, 1'b0, "R4 cs0 n1");
    run(1'b0, 20'h01238, 1'b0, 2'b01, 16'h0000, 16'h1357, 5, 1'b0, "R4 R7 cs0 n5");
    // write CS1, low byte only, code 01
    run(1'b0, 20'h45678, 1'b1, 2'b01, 16'hBEEF, 16'h0000, 1, 1'b0, "R9 cs1 write");
    // CS2 waits disabled: ready held low the whole cycle
    run(1'b0, 20'h8ABCD, 1'b0, 2'b10, 16'h0000, 16'h2468, 3, 1'b1, "R5 cs2 ignored");
    // multiplexed mode
    run(1'b1, 20'hC9ABC, 1'b0, 2'b11, 16'h0000, 16'h7777, 5, 1'b0, "R8 R4 cs3 mux n5");
    run(1'b1, 20'h40F0E, 1'b1, 2'b11, 16'hCAFE, 16'h0000, 0, 1'b0, "R8 R9 cs1 mux write");
    run(1'b1, 20'h81111, 1'b1, 2'b10, 16'hF00D, 16'h0000, 2, 1'b1, "R5 R8 cs2 mux");
    repeat (4) @(negedge clk);
    chk(pins() == 12'hFFA, "R2 idle after cycles", 64'(pins()), 64'hFFA);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule